// File: doc/BRIEF.md
# Serial Register Port with Burst Transfers

This block is the slave side of a framed serial configuration link. It holds a bank of thirty-two 8-bit registers. A host frame opens when the active-low enable falls. The first byte is an instruction, and one to four data bytes follow it. The instruction gives the direction, the burst length and the register where the burst starts. Each later byte uses the register one below the previous one.

The serial clock, enable and data inputs are oversampled in the block's system clock. This makes the serial edges into single-cycle pulses, so the whole port is ordinary synchronous logic. A configuration input selects the pin wiring:

- **3-wire:** read data leaves on the data pin, which is turned around after the instruction byte.
- **4-wire:** read data leaves on a separate output pin, and the data pin stays an input.

Pad enables are exported, so the pads can be tri-stated outside the block. The contents of the register bank appear on a flat output for the core logic.

Top module: `sreg_serial_port`

## Requirements
- R1: The instruction byte is sent MSB first. Bit 7 selects the direction (1 = read, 0 = write). Bits 6:5 hold the burst code. Bits 4:0 hold the start register. Data bytes are also MSB first.
- R2: Burst codes 0, 1, 2 and 3 move 1, 2, 3 and 4 data bytes. Bytes clocked after the burst is complete are not written. In a read they are shifted out as zero.
- R3: The first data byte uses the start register. Each later byte uses the register one lower. Stepping down from register 0 gives register 31.
- R4: Input bits are taken on rising serial clock edges. Output bits and output enables change only after falling serial clock edges.
- R5: In 3-wire mode, the data pin is driven only during the read data phase. Driving starts at the falling edge that ends the instruction byte. The separate output pin is never enabled.
- R6: In 4-wire mode, read data is driven on the separate output pin. The data pin is never enabled.
- R7: After the last read bit, the active output is driven low until the enable is released. The pin is then released.
- R8: Releasing the enable aborts a frame at any point. A partly received byte is never written. The next frame starts again with an instruction byte.
- R9: After reset, every register reads as zero and neither pin is enabled.
- R10: A written byte appears on `cfg_q` at bit position register×8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| four_wire | input | 1 | 1 = separate output pin, 0 = shared data pin |
| sclk | input | 1 | Serial clock from the host |
| sen_n | input | 1 | Active-low frame enable |
| sdio_in | input | 1 | Data pin input value |
| sdio_out | output | 1 | Data pin output value (3-wire reads) |
| sdio_oe | output | 1 | Data pin output enable |
| sdo_out | output | 1 | Separate output pin value (4-wire reads) |
| sdo_oe | output | 1 | Separate output pin enable |
| cfg_q | output | 256 | All registers, register i at bits i*8+7 : i*8 |

## Verification
The bench targets several corner cases:

- **Wrap past register 0.** A four-byte burst crosses from register 0 to register 31. A design that steps upward, or fails to wrap, writes or returns the wrong registers.
- **Bytes beyond the burst count.** Write frames carry bytes past the count. A design that ignores the count corrupts the register below the target, and a read returns stale data instead of zero.
- **Aborted frames.** Frames are dropped mid-byte and mid-instruction. A design that commits partial bytes changes a register. A design that keeps its counters misparses the next frame.
- **Pin timing in both wirings.** Output values are checked at two moments in each bit: just before the rising edge and again after it. The wrong pin being enabled, early turnaround in the instruction byte, output changing on the rising edge, or a missing low level at the end of a read all show up as mismatches.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;
   // Frame progress: instruction byte, burst data bytes, bytes past the burst
   typedef enum logic [1:0] {
      PH_INSTR = 2'd0,
      PH_DATA  = 2'd1,
      PH_DONE  = 2'd2
   } phase_e;
endpackage

// File: rtl/sreg_sync.sv
`timescale 1ns/1ps
module sreg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff <= {STAGES{RST_VAL}};
            end else begin
               ff[0] <= d;
               for (int k = 1; k < STAGES; k++) ff[k] <= ff[k-1];
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sreg_regfile.sv
`timescale 1ns/1ps
module sreg_regfile #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   localparam int NREG  = 1 << ADDR_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [ADDR_W-1:0]      waddr,
   input  logic [DATA_W-1:0]      wdata,
   input  logic [ADDR_W-1:0]      raddr,
   output logic [DATA_W-1:0]      rdata,
   output logic [NREG*DATA_W-1:0] regs_flat
);
   logic [DATA_W-1:0] mem [NREG];

   generate
      for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
         logic [DATA_W-1:0] q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               q_r <= '0;
            else if (we && waddr == ADDR_W'(gi))      q_r <= wdata;
         end
         assign mem[gi] = q_r;
         assign regs_flat[gi*DATA_W +: DATA_W] = q_r;
      end
   endgenerate

   assign rdata = mem[raddr];
endmodule

// File: rtl/sreg_frame.sv
`timescale 1ns/1ps
module sreg_frame
   import sreg_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle,     // enable released: abort and clear
   input  logic              rise,
   input  logic              fall,
   input  logic              din,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] raddr,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [DATA_W-1:0] wdata,
   output logic              dout,
   output logic              drive
);
   localparam int BIT_W  = $clog2(DATA_W);
   localparam int LEFT_W = CNT_W + 1;

   phase_e            phase_q;
   logic [BIT_W-1:0]  bit_q;
   logic [DATA_W-1:0] sr_q, sr_next, tx_q;
   logic              rd_q, dout_q, drive_q;
   logic [LEFT_W-1:0] left_q;
   logic [ADDR_W-1:0] addr_q;

   logic              byte_done, i_rd;
   logic [CNT_W-1:0]  i_cnt;
   logic [ADDR_W-1:0] i_addr;

   assign sr_next   = {sr_q[DATA_W-2:0], din};
   assign byte_done = rise && (bit_q == BIT_W'(DATA_W-1));
   assign i_rd      = sr_next[DATA_W-1];
   assign i_cnt     = sr_next[DATA_W-2 -: CNT_W];
   assign i_addr    = sr_next[ADDR_W-1:0];

   // First read byte is fetched straight from the arriving instruction
   assign raddr = (phase_q == PH_INSTR) ? i_addr : addr_q;
   assign we    = byte_done && (phase_q == PH_DATA) && !rd_q;
   assign waddr = addr_q;
   assign wdata = sr_next;
   assign dout  = dout_q;
   assign drive = drive_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || idle) begin
         phase_q <= PH_INSTR;
         bit_q   <= '0;
         sr_q    <= '0;
         rd_q    <= 1'b0;
         left_q  <= '0;
         addr_q  <= '0;
         tx_q    <= '0;
         dout_q  <= 1'b0;
         drive_q <= 1'b0;
      end else begin
         if (rise) begin
            sr_q  <= sr_next;
            bit_q <= bit_q + BIT_W'(1);
            if (byte_done) begin
               case (phase_q)
                  PH_INSTR: begin
                     rd_q    <= i_rd;
                     left_q  <= LEFT_W'(i_cnt) + LEFT_W'(1);
                     phase_q <= PH_DATA;
                     if (i_rd) begin
                        tx_q   <= rdata;
                        addr_q <= i_addr - ADDR_W'(1);
                     end else begin
                        tx_q   <= '0;
                        addr_q <= i_addr;
                     end
                  end
                  PH_DATA: begin
                     addr_q <= addr_q - ADDR_W'(1);
                     left_q <= left_q - LEFT_W'(1);
                     if (left_q == LEFT_W'(1)) phase_q <= PH_DONE;
                     tx_q <= (rd_q && left_q != LEFT_W'(1)) ? rdata : '0;
                  end
                  default: ;
               endcase
            end
         end
         if (fall && rd_q && phase_q != PH_INSTR) begin
            drive_q <= 1'b1;
            dout_q  <= tx_q[DATA_W-1];
            tx_q    <= {tx_q[DATA_W-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/sreg_serial_port.sv
`timescale 1ns/1ps
module sreg_serial_port #(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 2,
   parameter int SYNC_STAGES = 2,
   localparam int NREG       = 1 << ADDR_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   four_wire,
   input  logic                   sclk,
   input  logic                   sen_n,
   input  logic                   sdio_in,
   output logic                   sdio_out,
   output logic                   sdio_oe,
   output logic                   sdo_out,
   output logic                   sdo_oe,
   output logic [NREG*DATA_W-1:0] cfg_q
);
   generate
      if (1 + CNT_W + ADDR_W != DATA_W) begin : g_bad_layout
         $error("instruction fields must fill exactly one data word");
      end
      if (DATA_W != (1 << $clog2(DATA_W))) begin : g_bad_width
         $error("data width must be a power of two");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("synchronizer depth cannot be negative");
      end
   endgenerate

   logic sclk_s, sen_s, din_s, sclk_d;
   logic sclk_rise, sclk_fall;
   logic reg_we, dout, drive;
   logic [ADDR_W-1:0] raddr, waddr;
   logic [DATA_W-1:0] rdata, wdata;

   sreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk
      (.clk(clk), .rst_n(rst_n), .d(sclk),    .q(sclk_s));
   sreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sen
      (.clk(clk), .rst_n(rst_n), .d(sen_n),   .q(sen_s));
   sreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din
      (.clk(clk), .rst_n(rst_n), .d(sdio_in), .q(din_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   assign sclk_rise = sclk_s && !sclk_d && !sen_s;
   assign sclk_fall = !sclk_s && sclk_d && !sen_s;

   sreg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .idle(sen_s), .rise(sclk_rise), .fall(sclk_fall),
      .din(din_s), .rdata(rdata), .raddr(raddr), .we(reg_we), .waddr(waddr),
      .wdata(wdata), .dout(dout), .drive(drive)
   );

   sreg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(rdata), .regs_flat(cfg_q)
   );

   assign sdio_out = dout;
   assign sdo_out  = dout;
   assign sdio_oe  = drive && !four_wire;
   assign sdo_oe   = drive && four_wire;
endmodule

// File: rtl/sreg_serial_port_chk.sv
`timescale 1ns/1ps
module sreg_serial_port_chk (
   input logic clk,
   input logic rst_n,
   input logic sen_s,
   input logic rise,
   input logic fall,
   input logic we,
   input logic sdio_oe,
   input logic sdio_out,
   input logic sdo_oe,
   input logic sdo_out
);
   // R7: released enable turns both pins off one cycle later
   a_r7_release_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sen_s |=> (!sdio_oe && !sdo_oe));

   // R8: a register write needs a rising edge inside an open frame
   a_r8_write_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (rise && !sen_s));

   // R4: driven values move only after a falling edge
   a_r4_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && $past(sdo_oe) && sdo_out != $past(sdo_out)) |-> $past(fall));
   a_r4_sdio_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (sdio_oe && $past(sdio_oe) && sdio_out != $past(sdio_out)) |-> $past(fall));

   // R5: data pin turnaround begins at a falling edge
   a_r5_sdio_on_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdio_oe) |-> $past(fall));

   // R6: output pin turns on at a falling edge
   a_r6_sdo_on_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> $past(fall));
endmodule

bind sreg_serial_port sreg_serial_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sen_s(sen_s), .rise(sclk_rise), .fall(sclk_fall),
   .we(reg_we), .sdio_oe(sdio_oe), .sdio_out(sdio_out),
   .sdo_oe(sdo_oe), .sdo_out(sdo_out)
);

// File: tb/sreg_serial_port_tb_top.sv
`timescale 1ns/1ps
module sreg_serial_port_tb_top;
   localparam int H = 8;   // system clocks per serial half period

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, four_wire, sclk, sen_n, sdio_in;
   logic sdio_out, sdio_oe, sdo_out, sdo_oe;
   logic [255:0] cfg_q;

   sreg_serial_port dut_i (
      .clk(clk), .rst_n(rst_n), .four_wire(four_wire), .sclk(sclk), .sen_n(sen_n),
      .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
      .sdo_out(sdo_out), .sdo_oe(sdo_oe), .cfg_q(cfg_q)
   );

   int checks = 0, fails = 0;
   int oe_bad, hold_bad;
   logic end_out, end_oe, rel_oe;
   logic [7:0] model [32];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic act_out();
      return four_wire ? sdo_out : sdio_out;
   endfunction

   // Shift nbits of tx MSB first; capture the active output just before each rise
   task automatic shift_bits(input logic [7:0] tx, input int nbits,
                             input bit exp_drive, output logic [7:0] rx);
      logic a;
      rx = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
         sdio_in = tx[i];
         wclk(H);
         a = act_out();
         if ((four_wire ? sdo_oe : sdio_oe) !== exp_drive ||
             (four_wire ? sdio_oe : sdo_oe) !== 1'b0) oe_bad++;
         rx[i] = a;
         sclk = 1'b1;
         wclk(H);
         if (act_out() !== a) hold_bad++;
         sclk = 1'b0;
      end
   endtask

   task automatic do_frame(input bit rd, input logic [1:0] cnt, input logic [4:0] a,
                           input int nsend, input logic [31:0] wd,
                           output logic [31:0] rdv);
      logic [7:0] rx;
      oe_bad = 0; hold_bad = 0; rdv = '0;
      sen_n = 1'b0;
      wclk(4);
      shift_bits({rd, cnt, a}, 8, 1'b0, rx);
      for (int k = 0; k < nsend; k++) begin
         shift_bits(wd[31-8*k -: 8], 8, rd, rx);
         rdv[31-8*k -: 8] = rx;
      end
      wclk(H);
      end_out = act_out();
      end_oe  = four_wire ? sdo_oe : sdio_oe;
      sen_n = 1'b1;
      wclk(8);
      rel_oe = sdio_oe | sdo_oe;
   endtask

   task automatic check_all_regs(input string req);
      int bad = 0;
      for (int r = 0; r < 32; r++) if (cfg_q[r*8 +: 8] !== model[r]) bad++;
      chk(bad == 0, req, "register bank vs model mismatches", bad, 0);
   endtask

   task automatic t_reset();
      chk(cfg_q === '0, "R9", "cfg_q after reset", int'(cfg_q[31:0]), 0);
      chk(!sdio_oe && !sdo_oe, "R9", "enables after reset", {sdio_oe, sdo_oe}, 0);
   endtask

   task automatic t_write_single();
      logic [31:0] r;
      four_wire = 1'b0;
      do_frame(1'b0, 2'd0, 5'd5, 1, 32'hA500_0000, r);
      model[5] = 8'hA5;
      chk(cfg_q[5*8 +: 8] === 8'hA5, "R10", "reg5 after single write (R1)",
          cfg_q[5*8 +: 8], 8'hA5);
      chk(oe_bad == 0 && !rel_oe, "R5", "no drive during write frame", oe_bad, 0);
      check_all_regs("R1");
   endtask

   task automatic t_write_wrap();
      logic [31:0] r;
      do_frame(1'b0, 2'd3, 5'd2, 4, 32'h1122_3345, r);
      model[2] = 8'h11; model[1] = 8'h22; model[0] = 8'h33; model[31] = 8'h45;
      chk(cfg_q[31*8 +: 8] === 8'h45, "R3", "wrap write reaches reg31",
          cfg_q[31*8 +: 8], 8'h45);
      check_all_regs("R2");
   endtask

   task automatic t_read_3wire();
      logic [31:0] r;
      four_wire = 1'b0;
      do_frame(1'b1, 2'd3, 5'd2, 4, 32'h0, r);
      chk(r === 32'h1122_3345, "R3", "4-byte descending read 3-wire", r, 32'h1122_3345);
      chk(oe_bad == 0, "R5", "data pin only in read data phase", oe_bad, 0);
      chk(hold_bad == 0, "R4", "output stable across rising edge", hold_bad, 0);
      chk(end_out === 1'b0 && end_oe === 1'b1, "R7", "low after last bit",
          {end_oe, end_out}, 2);
      chk(rel_oe === 1'b0, "R7", "released after enable high", rel_oe, 0);
   endtask

   task automatic t_read_4wire();
      logic [31:0] r;
      four_wire = 1'b1;
      do_frame(1'b1, 2'd1, 5'd1, 2, 32'h0, r);
      chk(r[31:16] === 16'h2233, "R6", "2-byte read on output pin", r[31:16], 16'h2233);
      chk(oe_bad == 0, "R6", "data pin never enabled 4-wire", oe_bad, 0);
      chk(hold_bad == 0, "R4", "4-wire output stable across rise", hold_bad, 0);
      chk(end_out === 1'b0 && end_oe === 1'b1 && rel_oe === 1'b0, "R7",
          "4-wire end low then release", {end_oe, end_out, rel_oe}, 4);
      do_frame(1'b1, 2'd1, 5'd0, 2, 32'h0, r);
      chk(r[31:16] === 16'h3345, "R3", "read wraps 0 to 31", r[31:16], 16'h3345);
      four_wire = 1'b0;
   endtask

   task automatic t_count_limit();
      logic [31:0] r;
      do_frame(1'b0, 2'd0, 5'd10, 2, 32'h5AC3_0000, r);
      model[10] = 8'h5A;
      chk(cfg_q[9*8 +: 8] === 8'h00, "R2", "byte past count not written",
          cfg_q[9*8 +: 8], 0);
      chk(cfg_q[10*8 +: 8] === 8'h5A, "R2", "counted byte written",
          cfg_q[10*8 +: 8], 8'h5A);
      model[11] = 8'hFF;
      do_frame(1'b0, 2'd0, 5'd11, 1, 32'hFF00_0000, r);
      do_frame(1'b1, 2'd0, 5'd11, 2, 32'h0, r);
      chk(r[31:16] === 16'hFF00, "R2", "read past count shifts zero", r[31:16], 16'hFF00);
   endtask

   task automatic t_abort();
      logic [7:0] rx;
      logic [31:0] r;
      oe_bad = 0;
      sen_n = 1'b0; wclk(4);
      shift_bits({1'b0, 2'd0, 5'd7}, 8, 1'b0, rx);
      shift_bits(8'hFF, 5, 1'b0, rx);
      wclk(H); sen_n = 1'b1; wclk(8);
      chk(cfg_q[7*8 +: 8] === 8'h00, "R8", "partial byte discarded",
          cfg_q[7*8 +: 8], 0);
      sen_n = 1'b0; wclk(4);
      shift_bits(8'b1110_0000, 3, 1'b0, rx);
      wclk(H); sen_n = 1'b1; wclk(8);
      do_frame(1'b0, 2'd0, 5'd9, 1, 32'h7700_0000, r);
      model[9] = 8'h77;
      chk(cfg_q[9*8 +: 8] === 8'h77, "R8", "fresh frame after mid-instruction abort",
          cfg_q[9*8 +: 8], 8'h77);
      check_all_regs("R8");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      for (int r = 0; r < 32; r++) model[r] = 8'h00;
      rst_n = 1'b0; four_wire = 1'b0; sclk = 1'b0; sen_n = 1'b1; sdio_in = 1'b0;
      wclk(5);
      rst_n = 1'b1;
      wclk(5);
      t_reset();
      t_write_single();
      t_write_wrap();
      t_read_3wire();
      t_read_4wire();
      t_count_limit();
      t_abort();
      summary();
      $finish;
   end
endmodule